// File: doc/BRIEF.md
# Configuration Reload Command Sequencer

This block plays a fixed script of 16-bit command words into a device's internal configuration command port so that the device reloads itself from a chosen external flash location. The script opens with filler and synchronisation words, writes four general-purpose registers that hold a warm-boot image address and a fallback image address, sets a few further control registers, issues the reload command and closes with padding no-op words.

A one-cycle request, for example from a debounced pushbutton, starts the burst. The two 24-bit addresses are captured when the request is accepted and are split into register-write fields, each paired with a serial-flash read opcode. The block sends one half-word per clock with chip-enable and write-strobe held high, then reports done. Done stays set until reset, because the device is expected to reload and never return to this state.

Top module: `cfg_reload_seq`

## Requirements
- R1: While reset is low and right after it, `cs_o`, `wr_o`, `busy_o` and `done_o` are 0 and `cmd_o` is 0x0000.
- R2: A `start_i` high for one cycle while neither busy nor done makes `busy_o`, `cs_o` and `wr_o` high in the next cycle, with `cmd_o` = 0xFFFF.
- R3: The 28 half-words, by transfer index, are: 0,1: 0xFFFF; 2: 0xAA99; 3: 0x5566; 4: 0x31E1; 5: 0xFFFF; 6: 0x3261; 7: W1; 8: 0x3281; 9: W2; 10: 0x32A1; 11: F1; 12: 0x32C1; 13: F2; 14: 0x32E1; 15: 0x0000; 16: 0x30A1; 17: 0x0000; 18: 0x3301; 19: 0x2100; 20: 0x3201; 21: 0x001F; 22: 0x30A1; 23: 0x000E; 24 to 27: 0x2000.
- R4: W1 is warm-boot address bits [15:0]; W2 is 0x03 in bits [15:8] and warm-boot address bits [23:16] in bits [7:0]. F1 and F2 are built the same way from the fallback address.
- R5: `cs_o` and `wr_o` stay high together for exactly 28 consecutive cycles, one new half-word per cycle, with no gap, each 32-bit script word sent upper half first.
- R6: In the cycle after the last no-op, `cs_o`, `wr_o` and `busy_o` are 0 and `done_o` is 1.
- R7: Once `done_o` is 1 it stays 1 and every further `start_i` is ignored until reset: no transfer occurs.
- R8: A `start_i` while busy is dropped: it neither restarts, lengthens nor queues a burst.
- R9: Both addresses are sampled in the accepting cycle; changes to them during a burst do not alter the words sent.
- R10: `cmd_o` is 0x0000 in every cycle in which `cs_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle reload request |
| warm_addr_i | input | 24 | Flash byte address of warm-boot image |
| fall_addr_i | input | 24 | Flash byte address of fallback image |
| cmd_o | output | 16 | Command half-word to configuration port |
| cs_o | output | 1 | Command port chip-enable, active high |
| wr_o | output | 1 | Command port write strobe, active high |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | Script fully sent; sticky until reset |

## Verification
The assertions watch every cycle for the accept-to-first-word timing, a burst length of exactly 28 strobed cycles, done following the end of busy, done staying set, and a quiet command bus while the enable is low. Only the bench scenarios can show the word contents and their order, the field packing for distinct address patterns, and that requests during a burst or after done, and address changes mid-burst, leave the transferred words untouched.

// File: rtl/cfg_reload_pkg.sv
package cfg_reload_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  localparam int unsigned HDR_LEN = 24;  // words before the no-op tail
  localparam logic [15:0] NOOP_HW = 16'h2000;
endpackage

// File: rtl/cfg_word_mux.sv
module cfg_word_mux #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned IDX_W   = 5,
  parameter logic [7:0]  READ_OP = 8'h03
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] warm_addr_i,
  input  logic [ADDR_W-1:0] fall_addr_i,
  output logic [DATA_W-1:0] word_o
);
  import cfg_reload_pkg::*;

  localparam int unsigned HI_W = ADDR_W - DATA_W;
  localparam int unsigned OP_W = DATA_W - HI_W;

  logic [DATA_W-1:0] warm_lo, warm_hi, fall_lo, fall_hi, sel;

  assign warm_lo = warm_addr_i[DATA_W-1:0];
  assign fall_lo = fall_addr_i[DATA_W-1:0];
  assign warm_hi = {READ_OP[OP_W-1:0], warm_addr_i[ADDR_W-1:DATA_W]};
  assign fall_hi = {READ_OP[OP_W-1:0], fall_addr_i[ADDR_W-1:DATA_W]};

  always_comb begin
    case (int'(idx_i))
      0, 1:    sel = 16'hFFFF;
      2:       sel = 16'hAA99;
      3:       sel = 16'h5566;
      4:       sel = 16'h31E1;
      5:       sel = 16'hFFFF;
      6:       sel = 16'h3261;
      7:       sel = warm_lo;
      8:       sel = 16'h3281;
      9:       sel = warm_hi;
      10:      sel = 16'h32A1;
      11:      sel = fall_lo;
      12:      sel = 16'h32C1;
      13:      sel = fall_hi;
      14:      sel = 16'h32E1;
      15:      sel = 16'h0000;
      16:      sel = 16'h30A1;
      17:      sel = 16'h0000;
      18:      sel = 16'h3301;
      19:      sel = 16'h2100;
      20:      sel = 16'h3201;
      21:      sel = 16'h001F;
      22:      sel = 16'h30A1;  // reload command register
      23:      sel = 16'h000E;
      default: sel = NOOP_HW;
    endcase
  end

  assign word_o = en_i ? sel : '0;
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl #(
  parameter int unsigned SCRIPT_LEN = 28,
  parameter int unsigned IDX_W      = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             send_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o
);
  import cfg_reload_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SCRIPT_LEN - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign load_o = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_SEND;
        idx_d   = '0;
      end
      ST_SEND: begin
        if (idx_q == LAST_IDX) state_d = ST_DONE;
        else                   idx_d   = idx_q + 1'b1;
      end
      ST_DONE: state_d = ST_DONE;  // wait for device reload / reset
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign send_o = (state_q == ST_SEND);
  assign done_o = (state_q == ST_DONE);
  assign idx_o  = idx_q;
endmodule

// File: rtl/cfg_reload_seq.sv
module cfg_reload_seq #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned NOOP_PAIRS = 2,
  parameter logic [7:0]  READ_OP    = 8'h03
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] warm_addr_i,
  input  logic [ADDR_W-1:0] fall_addr_i,
  output logic [DATA_W-1:0] cmd_o,
  output logic              cs_o,
  output logic              wr_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned SCRIPT_LEN = cfg_reload_pkg::HDR_LEN + 2 * 2 * NOOP_PAIRS / 2 * 1;
  localparam int unsigned IDX_W      = $clog2(SCRIPT_LEN);

  logic              load, send;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] warm_q, fall_q;

  cfg_seq_ctrl #(.SCRIPT_LEN(SCRIPT_LEN), .IDX_W(IDX_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .send_o (send),
    .done_o (done_o),
    .idx_o  (idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm_q <= '0;
      fall_q <= '0;
    end else if (load) begin
      warm_q <= warm_addr_i;
      fall_q <= fall_addr_i;
    end
  end

  cfg_word_mux #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .READ_OP(READ_OP)
  ) u_mux (
    .idx_i      (idx),
    .en_i       (send),
    .warm_addr_i(warm_q),
    .fall_addr_i(fall_q),
    .word_o     (cmd_o)
  );

  assign cs_o   = send;
  assign wr_o   = send;
  assign busy_o = send;
endmodule

// File: rtl/cfg_reload_seq_chk.sv
module cfg_reload_seq_chk #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SCRIPT_LEN = 28
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [DATA_W-1:0] cmd_o,
  input logic              cs_o,
  input logic              wr_o,
  input logic              busy_o,
  input logic              done_o
);
  localparam int unsigned CNT_W = $clog2(SCRIPT_LEN) + 2;

  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   run_cnt <= '0;
    else if (cs_o) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  a_r2_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && !done_o |=> busy_o && cs_o && wr_o && cmd_o == 16'hFFFF);

  a_r5_burst_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> run_cnt == CNT_W'(SCRIPT_LEN));

  a_r5_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt <= CNT_W'(SCRIPT_LEN));

  a_r6_done_after: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o && !cs_o && !wr_o);

  a_r7_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && !busy_o && !cs_o);

  a_r10_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> cmd_o == '0);
endmodule

bind cfg_reload_seq cfg_reload_seq_chk #(.DATA_W(DATA_W), .SCRIPT_LEN(SCRIPT_LEN)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .cmd_o  (cmd_o),
  .cs_o   (cs_o),
  .wr_o   (wr_o),
  .busy_o (busy_o),
  .done_o (done_o)
);

// File: tb/cfg_reload_seq_bench.sv
module cfg_reload_seq_bench;
  localparam int NWORDS = 28;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] warm_addr_i = '0;
  logic [23:0] fall_addr_i = '0;
  logic [15:0] cmd_o;
  logic        cs_o, wr_o, busy_o, done_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] exp_q[$];

  always #4 clk = ~clk;  // 125 MHz

  cfg_reload_seq u_cfg_reload_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .warm_addr_i(warm_addr_i), .fall_addr_i(fall_addr_i),
    .cmd_o(cmd_o), .cs_o(cs_o), .wr_o(wr_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int i, input logic [23:0] w, input logic [23:0] f);
    case (i)
      0, 1, 5: return 16'hFFFF;
      2:  return 16'hAA99;
      3:  return 16'h5566;
      4:  return 16'h31E1;
      6:  return 16'h3261;
      7:  return w[15:0];
      8:  return 16'h3281;
      9:  return {8'h03, w[23:16]};
      10: return 16'h32A1;
      11: return f[15:0];
      12: return 16'h32C1;
      13: return {8'h03, f[23:16]};
      14: return 16'h32E1;
      15, 17: return 16'h0000;
      16, 22: return 16'h30A1;
      18: return 16'h3301;
      19: return 16'h2100;
      20: return 16'h3201;
      21: return 16'h001F;
      23: return 16'h000E;
      default: return 16'h2000;
    endcase
  endfunction

  // monitor: every strobed cycle pops one expected word (R3, R4, R5)
  always @(negedge clk) begin
    if (rst_ni) begin
      if (cs_o) begin
        check("R5 wr with cs", {31'd0, wr_o}, 32'd1);
        if (exp_q.size() == 0) check("R5 extra transfer", {16'd0, cmd_o}, 32'hDEAD);
        else check("R3/R4 word", {16'd0, cmd_o}, {16'd0, exp_q.pop_front()});
      end else begin
        check("R10 idle bus", {16'd0, cmd_o}, 32'd0);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    start_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset outputs", {16'd0, cmd_o, 4'd0, cs_o, wr_o, busy_o, done_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after reset", {16'd0, cmd_o, 4'd0, cs_o, wr_o, busy_o, done_o}, 32'd0);
  endtask

  // driver: pushes expected script, pulses start, optionally disturbs mid-burst
  task automatic run_burst(input logic [23:0] w, input logic [23:0] f, input bit disturb);
    for (int i = 0; i < NWORDS; i++) exp_q.push_back(exp_word(i, w, f));
    warm_addr_i = w;
    fall_addr_i = f;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy on accept", {29'd0, busy_o, cs_o, wr_o}, 32'd7);
    for (int c = 1; c < NWORDS; c++) begin
      if (disturb && c == 4) begin
        start_i = 1'b1;          // R8: dropped
        warm_addr_i = ~w;        // R9: ignored
        fall_addr_i = ~f;
      end
      if (disturb && c == 5) start_i = 1'b0;
      @(negedge clk);
      check("R5 busy through burst", {31'd0, busy_o}, 32'd1);
    end
    @(negedge clk);
    check("R6 end of burst", {28'd0, cs_o, wr_o, busy_o, done_o}, 32'd1);
    check("R5/R8 all words sent", exp_q.size(), 0);
  endtask

  initial begin
    fork
      begin
        do_reset();
        run_burst(24'h123456, 24'hABCDEF, 1'b0);
        // R7: start after done ignored
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) begin
          @(negedge clk);
          check("R7 no restart after done", {30'd0, cs_o, done_o}, 32'd1);
        end
        do_reset();
        run_burst(24'hFF00A5, 24'h010000, 1'b1);  // R8, R9
        do_reset();
        run_burst(24'h000000, 24'hFFFFFF, 1'b0);
        do_reset();
        run_burst(24'h5A0F3C, 24'h80C001, 1'b1);
        repeat (3) @(negedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        check("watchdog expired", 32'd1, 32'd0);
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule